// File: doc/BRIEF.md
# Streaming write-allocate throttle

This block sits beside an L1 data cache. For each store that misses, it decides whether the missing line is brought into the cache (allocate) or the store is sent around it (no-allocate). It watches the stream of completed line writes and counts runs of full-line writes in which each line address is the previous one plus one. When a run reaches a length chosen by a 2-bit mode, allocation stops. A long streaming copy then passes the cache without flushing it. Below that length, and in the mode with no throttle, the page's write-allocate attribute decides.

The mode is held in a register inside the block. It is loaded by a write strobe, and in the hint control register its field sits at bits 4:3. Completed line writes come in on one port, with a flag that says whether the whole line was written. A separate strobe reports a load or a non-sequential store, and that strobe breaks the run. A miss query carries the page attribute. The answer comes back registered, one cycle later. A query uses the run state from before any line event in the same cycle.

Top module: `wa_throttle`

## Requirements
- R1: After reset, `decValid` is low, the mode is 0 and the run counter is zero. A first miss with `pageWa`=1 is answered `decAlloc`=1.
- R2: In mode 0, `decAlloc` equals the `pageWa` of the query, whatever line writes came before it.
- R3: In mode 1, once 3 adjacent full-line writes have been counted, a miss is answered `decAlloc`=0. After 2 such writes it is still answered by `pageWa`.
- R4: In mode 2 the threshold is 64 adjacent full-line writes. After 63 such writes the answer is allocate, and after 64 it is no-allocate.
- R5: In mode 3 the threshold is 128 adjacent full-line writes. After 127 such writes the answer is allocate, and after 128 it is no-allocate.
- R6: A full-line write extends the run only if the run is non-empty and its line address equals the last counted address plus one. Any other full-line write starts a new run of length 1.
- R7: A `breakRun` pulse clears the run counter, and so does a line write with `lineFull`=0. Allocation then resumes.
- R8: In modes 1 to 3, while the run is below the threshold, `decAlloc` equals `pageWa`. A query with `pageWa`=0 is therefore never answered allocate.
- R9: The counter saturates at the threshold. Further adjacent writes keep the answer at no-allocate until the run is broken.
- R10: A mode write (`modeWe`=1) loads `modeIn` and clears the run counter, even when the mode value does not change.
- R11: `decValid` is high in exactly the cycle after a cycle with `missValid`=1, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWe | input | 1 | Write strobe for the mode register |
| modeIn | input | 2 | New mode: 0 follows the page attribute, 1/2/3 set thresholds of 3/64/128 |
| lineWrValid | input | 1 | A line write has completed this cycle |
| lineFull | input | 1 | The completed line write covered the whole line |
| lineAddr | input | LINE_W | Line address of the completed line write |
| breakRun | input | 1 | A load or a non-sequential store occurred |
| missValid | input | 1 | A store miss query |
| pageWa | input | 1 | Page write-allocate attribute of the missing store |
| decValid | output | 1 | The decision is valid (one cycle after the query) |
| decAlloc | output | 1 | 1 = allocate the line, 0 = write around it |

## Verification
The bench feeds ascending full-line runs that stop just short of each mode's threshold and then reach it. The answer at those two points tells an off-by-one threshold from a correct one, and it tells one mode's threshold from another's. Runs broken by a non-adjacent address, a partial line, a load strobe or a mode rewrite show whether each of these clears or restarts the counter. Queries with the page attribute both high and low, in mode 0 and below the threshold, separate an ignored attribute from a followed one. A run pushed well past 128 lines checks that saturation holds until a break.

// File: rtl/wa_throttle_pkg.sv
package wa_throttle_pkg;
  typedef struct packed {
    logic loadMode;
    logic clrRun;
    logic startRun;
    logic extendRun;
  } runStrobes_t;
endpackage

// File: rtl/wa_throttle_ctrl.sv
module wa_throttle_ctrl
  import wa_throttle_pkg::*;
(
  input  logic        modeWe,
  input  logic        lineWrValid,
  input  logic        lineFull,
  input  logic        breakRun,
  input  logic        isAdjacent,
  input  logic        runActive,
  output runStrobes_t strobes
);
  logic fullWrite;
  logic clearNow;

  always_comb begin
    fullWrite = lineWrValid & lineFull;
    // a mode write, a load or a partial line ends the run; these win over a line event
    clearNow = modeWe | breakRun | (lineWrValid & ~lineFull);
    strobes.loadMode  = modeWe;
    strobes.clrRun    = clearNow;
    strobes.extendRun = ~clearNow & fullWrite & runActive & isAdjacent;
    strobes.startRun  = ~clearNow & fullWrite & ~(runActive & isAdjacent);
  end
endmodule

// File: rtl/wa_throttle_dp.sv
module wa_throttle_dp
  import wa_throttle_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int THR1   = 3,
  parameter int THR2   = 64,
  parameter int THR3   = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  runStrobes_t       strobes,
  input  logic [1:0]        modeIn,
  input  logic [LINE_W-1:0] lineAddr,
  input  logic              missValid,
  input  logic              pageWa,
  output logic              isAdjacent,
  output logic              runActive,
  output logic              decValid,
  output logic              decAlloc
);
  localparam int CNT_W = $clog2(THR3 + 1);

  logic [1:0]        modeQ;
  logic [CNT_W-1:0]  runCnt;
  logic [CNT_W-1:0]  limit;
  logic [LINE_W-1:0] lastAddr;
  logic              atLimit;

  always_comb begin
    unique case (modeQ)
      2'd1:    limit = CNT_W'(THR1);
      2'd2:    limit = CNT_W'(THR2);
      default: limit = CNT_W'(THR3);
    endcase
  end

  assign isAdjacent = (lineAddr == lastAddr + LINE_W'(1));
  assign runActive  = (runCnt != '0);
  assign atLimit    = (modeQ != 2'd0) && (runCnt >= limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= 2'd0;
      runCnt   <= '0;
      lastAddr <= '0;
      decValid <= 1'b0;
      decAlloc <= 1'b0;
    end else begin
      if (strobes.loadMode) modeQ <= modeIn;
      if (strobes.clrRun) begin
        runCnt <= '0;
      end else if (strobes.startRun) begin
        runCnt   <= CNT_W'(1);
        lastAddr <= lineAddr;
      end else if (strobes.extendRun) begin
        lastAddr <= lineAddr;
        if (runCnt < limit) runCnt <= runCnt + CNT_W'(1);
      end
      decValid <= missValid;
      decAlloc <= missValid & pageWa & ~atLimit;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= CNT_W'(THR3)); // R9
  AST_SATURATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.extendRun && runCnt == limit && !strobes.loadMode) |=> (runCnt == $past(runCnt))); // R9
  AST_CLEAR_RUN: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrRun |=> (runCnt == '0)); // R7
  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadMode |=> (runCnt == '0 && modeQ == $past(modeIn))); // R10
  AST_START_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startRun |=> (runCnt == CNT_W'(1))); // R6
  AST_DEC_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    missValid |=> decValid); // R11
  AST_DEC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !missValid |=> !decValid); // R11
  AST_MODE0_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && modeQ == 2'd0) |=> (decAlloc == $past(pageWa))); // R2
  AST_NO_WA_NO_ALLOC: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && !pageWa) |=> !decAlloc); // R8
endmodule

// File: rtl/wa_throttle.sv
module wa_throttle
  import wa_throttle_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int THR1   = 3,
  parameter int THR2   = 64,
  parameter int THR3   = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWe,
  input  logic [1:0]        modeIn,
  input  logic              lineWrValid,
  input  logic              lineFull,
  input  logic [LINE_W-1:0] lineAddr,
  input  logic              breakRun,
  input  logic              missValid,
  input  logic              pageWa,
  output logic              decValid,
  output logic              decAlloc
);
  runStrobes_t strobes;
  logic        isAdjacent;
  logic        runActive;

  wa_throttle_ctrl u_ctrl (
    .modeWe      (modeWe),
    .lineWrValid (lineWrValid),
    .lineFull    (lineFull),
    .breakRun    (breakRun),
    .isAdjacent  (isAdjacent),
    .runActive   (runActive),
    .strobes     (strobes)
  );

  wa_throttle_dp #(
    .LINE_W (LINE_W),
    .THR1   (THR1),
    .THR2   (THR2),
    .THR3   (THR3)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .modeIn     (modeIn),
    .lineAddr   (lineAddr),
    .missValid  (missValid),
    .pageWa     (pageWa),
    .isAdjacent (isAdjacent),
    .runActive  (runActive),
    .decValid   (decValid),
    .decAlloc   (decAlloc)
  );
endmodule

// File: tb/wa_throttle_tb.sv
module wa_throttle_tb;
  localparam int LINE_W = 26;
  // op codes of the vector table
  localparam logic [2:0] OP_MODE = 3'd0, OP_FULL = 3'd1, OP_PART = 3'd2,
                         OP_BRK = 3'd3, OP_MISS = 3'd4;
  // entry: op[22:20] req[19:16] exp[15] data[14:0]; for OP_MISS data[0] = pageWa
  localparam int NV = 37;
  localparam logic [22:0] VEC [0:NV-1] = '{
    {OP_MISS, 4'd1,  1'b1, 15'd1},   // R1 first miss allocates
    {OP_MODE, 4'd0,  1'b0, 15'd1},
    {OP_FULL, 4'd0,  1'b0, 15'd10},
    {OP_FULL, 4'd0,  1'b0, 15'd11},
    {OP_MISS, 4'd8,  1'b1, 15'd1},   // R8 below threshold follows page
    {OP_MISS, 4'd8,  1'b0, 15'd0},   // R8
    {OP_FULL, 4'd0,  1'b0, 15'd12},
    {OP_MISS, 4'd3,  1'b0, 15'd1},   // R3 third line stops allocation
    {OP_FULL, 4'd0,  1'b0, 15'd13},
    {OP_MISS, 4'd9,  1'b0, 15'd1},   // R9 stays saturated
    {OP_BRK,  4'd0,  1'b0, 15'd0},
    {OP_MISS, 4'd7,  1'b1, 15'd1},   // R7 load breaks run
    {OP_FULL, 4'd0,  1'b0, 15'd20},
    {OP_FULL, 4'd0,  1'b0, 15'd21},
    {OP_FULL, 4'd0,  1'b0, 15'd22},
    {OP_MISS, 4'd3,  1'b0, 15'd1},   // R3
    {OP_PART, 4'd0,  1'b0, 15'd23},
    {OP_MISS, 4'd7,  1'b1, 15'd1},   // R7 partial line breaks run
    {OP_FULL, 4'd0,  1'b0, 15'd30},
    {OP_FULL, 4'd0,  1'b0, 15'd31},
    {OP_FULL, 4'd0,  1'b0, 15'd40},
    {OP_FULL, 4'd0,  1'b0, 15'd41},
    {OP_MISS, 4'd6,  1'b1, 15'd1},   // R6 gap restarted run at 1
    {OP_FULL, 4'd0,  1'b0, 15'd42},
    {OP_MISS, 4'd6,  1'b0, 15'd1},   // R6
    {OP_MODE, 4'd0,  1'b0, 15'd0},
    {OP_MISS, 4'd10, 1'b1, 15'd1},   // R10
    {OP_FULL, 4'd0,  1'b0, 15'd50},
    {OP_FULL, 4'd0,  1'b0, 15'd51},
    {OP_FULL, 4'd0,  1'b0, 15'd52},
    {OP_FULL, 4'd0,  1'b0, 15'd53},
    {OP_MISS, 4'd2,  1'b1, 15'd1},   // R2 mode 0 ignores run
    {OP_MISS, 4'd2,  1'b0, 15'd0},   // R2
    {OP_MODE, 4'd0,  1'b0, 15'd1},
    {OP_FULL, 4'd0,  1'b0, 15'd60},
    {OP_FULL, 4'd0,  1'b0, 15'd61},
    {OP_FULL, 4'd0,  1'b0, 15'd62}
  };

  logic clk = 1'b0;
  logic rstN;
  logic modeWe, lineWrValid, lineFull, breakRun, missValid, pageWa;
  logic [1:0] modeIn;
  logic [LINE_W-1:0] lineAddr;
  logic decValid, decAlloc;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wa_throttle #(.LINE_W(LINE_W)) u_dut (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeIn(modeIn),
    .lineWrValid(lineWrValid), .lineFull(lineFull), .lineAddr(lineAddr),
    .breakRun(breakRun), .missValid(missValid), .pageWa(pageWa),
    .decValid(decValid), .decAlloc(decAlloc)
  );

  task automatic check(input int req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    modeWe = 0; modeIn = 0; lineWrValid = 0; lineFull = 0;
    lineAddr = '0; breakRun = 0; missValid = 0; pageWa = 0;
  endtask

  // drive one op for a cycle, return at the following falling edge
  task automatic doOp(input logic [2:0] op, input logic [14:0] data);
    @(negedge clk);
    clearIn();
    case (op)
      OP_MODE: begin modeWe = 1; modeIn = data[1:0]; end
      OP_FULL: begin lineWrValid = 1; lineFull = 1; lineAddr = LINE_W'(data); end
      OP_PART: begin lineWrValid = 1; lineFull = 0; lineAddr = LINE_W'(data); end
      OP_BRK:  breakRun = 1;
      default: begin missValid = 1; pageWa = data[0]; end
    endcase
    @(negedge clk);
    clearIn();
  endtask

  task automatic fullRun(input int base, input int n);
    for (int i = 0; i < n; i++) doOp(OP_FULL, 15'(base + i));
  endtask

  task automatic missCheck(input int req, input logic wa, input logic exp, input string what);
    doOp(OP_MISS, {14'd0, wa});
    check(req, decAlloc, exp, what);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clearIn();
    rstN = 0;
    repeat (3) @(negedge clk);
    check(1, decValid, 1'b0, "decValid in reset");   // R1
    rstN = 1;
    @(negedge clk);
    check(1, decValid, 1'b0, "decValid after reset"); // R1

    for (int v = 0; v < NV; v++) begin
      doOp(VEC[v][22:20], VEC[v][14:0]);
      if (VEC[v][22:20] == OP_MISS)
        check(int'(VEC[v][19:16]), decAlloc, VEC[v][15], $sformatf("vector %0d", v));
    end
    // mode 1 run 60..62 is saturated; rewriting the same mode clears it
    missCheck(3, 1'b1, 1'b0, "mode1 three lines");
    doOp(OP_MODE, 15'd1);
    missCheck(10, 1'b1, 1'b1, "same-mode rewrite clears run"); // R10

    // R11 decision timing
    doOp(OP_MISS, 15'd1);
    check(11, decValid, 1'b1, "decValid after miss");
    @(negedge clk);
    check(11, decValid, 1'b0, "decValid idle");

    // R4 mode 2
    doOp(OP_MODE, 15'd2);
    fullRun(1000, 63);
    missCheck(4, 1'b1, 1'b1, "mode2 after 63");
    doOp(OP_FULL, 15'd1063);
    missCheck(4, 1'b1, 1'b0, "mode2 after 64");

    // R5 mode 3 and R9 saturation
    doOp(OP_MODE, 15'd3);
    fullRun(2000, 127);
    missCheck(5, 1'b1, 1'b1, "mode3 after 127");
    doOp(OP_FULL, 15'd2127);
    missCheck(5, 1'b1, 1'b0, "mode3 after 128");
    fullRun(2128, 72);
    missCheck(9, 1'b1, 1'b0, "mode3 saturated at 200");
    doOp(OP_BRK, 15'd0);
    missCheck(7, 1'b1, 1'b1, "break after saturation");
    fullRun(3000, 5);
    missCheck(6, 1'b1, 1'b1, "new run of 5 in mode3");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule